// File: doc/BRIEF.md
# Address-Encoded Function Call Mailbox

This block lets host software call a small hardware function over a snooping processor bus, using one reserved 4 KB page as a mailbox. The page is mapped write-through, so every store to it appears on the bus as a write transaction. The block watches the bus. When a write falls inside the page, it takes the call arguments from the low address bits and from the written data, runs a fixed-latency lookup of memory access latency, and keeps the result.

A later bus read of the same page is claimed in the snoop phase, in the way a cache holding a modified copy of the line claims it. If the result is not ready yet, the snoop phase is stretched with stall cycles. After the claim, the block supplies the whole 32-byte line as consecutive 64-bit beats, in the way of a cache-to-cache transfer. The page location is set through a base register. Three counters record accepted writes, accepted reads and stall cycles.

Top module: `busmbx_offload`

## Requirements
- R1: While reset is held and at its release, snp_stall, snp_hitm and dat_valid are 0, all three statistics counters are 0, and the page base is the RESET_PFN parameter (default 0).
- R2: A bus transaction whose address bits above bit 11 differ from the page base gets no snoop response and changes neither the held result nor any counter.
- R3: A pulse on cfg_base_we loads cfg_base_pfn as the new page base on that clock edge. From then on the new page is served and the old page is ignored.
- R4: A page write carries its arguments as follows: access kind in address bits [4:3], memory level in bits [6:5], and an extra penalty in data bits [15:0]. Address bits [2:0] and [11:7] are ignored. The result is base(level) + adj(kind) + penalty. The base values are 3, 11, 35 and 120 for levels 0 to 3, and the adj values are 0, 2, 1 and 4 for kinds 0 to 3.
- R5: The result is valid FUNC_LAT (default 4) clock edges after the edge that takes the argument write. A page read taken on that edge or later sees snp_hitm in the first cycle after its request edge, with no stall.
- R6: A page read taken before the result is valid drives snp_stall each cycle until the result is valid, and then drives snp_hitm for one cycle. snp_stall and snp_hitm are never high together. A write accepted during the stall restarts the function, and the stalled read is answered with the newest result.
- R7: In the BEATS (default 4) cycles after the snp_hitm cycle, dat_valid is high and dat_beat counts 0, 1, 2, 3. Beat 0 carries the result, zero-extended. The other beats carry zero. dat_valid is low afterwards.
- R8: A read request that arrives while a response is in progress (stall, claim or data) is ignored: it gets no response and is not counted.
- R9: stat_writes counts accepted page writes, stat_reads counts accepted page reads, and stat_stalls counts cycles with snp_stall high.
- R10: The result persists. A second page read with no write in between returns the same result without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_we | input | 1 | Load strobe for the page base |
| cfg_base_pfn | input | ADDR_W-12 | New page base (address bits above the page offset) |
| bus_req_valid | input | 1 | A bus request is present this cycle |
| bus_req_write | input | 1 | 1 for a write transaction, 0 for a read |
| bus_req_addr | input | ADDR_W | Request address |
| bus_req_wdata | input | DATA_W | Write data of the request |
| snp_stall | output | 1 | Snoop phase stretched, result not ready |
| snp_hitm | output | 1 | Line claimed as modified, data follows |
| dat_valid | output | 1 | A data beat is driven |
| dat_beat | output | log2(BEATS) | Index of the current beat |
| dat_data | output | DATA_W | Beat data |
| stat_writes | output | STAT_W | Accepted page writes |
| stat_reads | output | STAT_W | Accepted page reads |
| stat_stalls | output | STAT_W | Stall cycles driven |

## Verification
The bench calls the function with every memory level and every access kind. It uses penalties of zero, small, mid-range and full 16-bit values, and sets junk in the ignored address bits, so a swapped field, a wrong table entry or a truncated sum each gives a different result. Reads are placed exactly on the ready edge, early by several cycles, and inside a running response. This separates a latency that is off by one, a missing stall and a reply with a stale result. Off-page and old-page traffic after a base change shows whether the block is decoding the page.

// File: rtl/busmbx_pkg.sv
`timescale 1ns/1ps
package busmbx_pkg;

   typedef enum logic [1:0] {
      RS_IDLE  = 2'd0,
      RS_SNOOP = 2'd1,
      RS_DATA  = 2'd2
   } resp_state_e;

   typedef struct packed {
      logic [1:0]  kind;
      logic [1:0]  level;
      logic [15:0] extra;
   } call_args_t;

   // Latency lookup: base cost per memory level plus an adjustment per access kind.
   function automatic logic [11:0] lat_lookup(input logic [1:0] kind, input logic [1:0] level);
      logic [11:0] base;
      logic [11:0] adj;
      case (level)
         2'd0:    base = 12'd3;
         2'd1:    base = 12'd11;
         2'd2:    base = 12'd35;
         default: base = 12'd120;
      endcase
      case (kind)
         2'd0:    adj = 12'd0;
         2'd1:    adj = 12'd2;
         2'd2:    adj = 12'd1;
         default: adj = 12'd4;
      endcase
      return base + adj;
   endfunction

endpackage

// File: rtl/busmbx_decode.sv
`timescale 1ns/1ps
module busmbx_decode
   import busmbx_pkg::*;
#(
   parameter int ADDR_W    = 36,
   parameter int DATA_W    = 64,
   parameter int PAGE_BITS = 12,
   parameter logic [ADDR_W-PAGE_BITS-1:0] RESET_PFN = '0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [ADDR_W-PAGE_BITS-1:0] cfg_pfn,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   input  logic                        resp_idle,
   output logic                        wr_call,
   output logic                        rd_call,
   output call_args_t                  args,
   output logic [ADDR_W-PAGE_BITS-1:0] page_pfn
);
   localparam int PFN_W = ADDR_W - PAGE_BITS;

   logic [PFN_W-1:0] base_q;
   logic             page_hit;

   always_ff @(posedge clk) begin
      if (!rst_n)
         base_q <= RESET_PFN;
      else if (cfg_we)
         base_q <= cfg_pfn;
   end

   always_comb begin
      page_hit   = req_valid && (req_addr[ADDR_W-1:PAGE_BITS] == base_q);
      wr_call    = page_hit && req_write;
      rd_call    = page_hit && !req_write && resp_idle;
      args.kind  = req_addr[4:3];
      args.level = req_addr[6:5];
      args.extra = req_wdata[15:0];
      page_pfn   = base_q;
   end

endmodule

// File: rtl/busmbx_func.sv
`timescale 1ns/1ps
module busmbx_func
   import busmbx_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int FUNC_LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  call_args_t        args,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data
);
   localparam int CNT_W = (FUNC_LAT > 1) ? $clog2(FUNC_LAT) : 1;

   call_args_t        arg_q;
   logic              busy_q;
   logic              valid_q;
   logic [DATA_W-1:0] res_q;
   logic [DATA_W-1:0] calc;

   always_comb begin
      calc = DATA_W'(lat_lookup(arg_q.kind, arg_q.level)) + DATA_W'(arg_q.extra);
   end

   generate
      if (FUNC_LAT == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               arg_q   <= '0;
               busy_q  <= 1'b0;
               valid_q <= 1'b0;
               res_q   <= '0;
            end else if (start) begin
               arg_q   <= args;
               busy_q  <= 1'b1;
               valid_q <= 1'b0;
            end else if (busy_q) begin
               res_q   <= calc;
               valid_q <= 1'b1;
               busy_q  <= 1'b0;
            end
         end
      end else begin : g_counted
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               arg_q   <= '0;
               busy_q  <= 1'b0;
               valid_q <= 1'b0;
               res_q   <= '0;
               cnt_q   <= '0;
            end else if (start) begin
               arg_q   <= args;
               busy_q  <= 1'b1;
               valid_q <= 1'b0;
               cnt_q   <= CNT_W'(FUNC_LAT - 1);
            end else if (busy_q) begin
               if (cnt_q == '0) begin
                  res_q   <= calc;
                  valid_q <= 1'b1;
                  busy_q  <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
         end
      end
   endgenerate

   assign res_valid = valid_q;
   assign res_data  = res_q;

endmodule

// File: rtl/busmbx_resp.sv
`timescale 1ns/1ps
module busmbx_resp
   import busmbx_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int BEATS  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_rd,
   input  logic                     res_valid,
   input  logic [DATA_W-1:0]        res_data,
   output logic                     snp_stall,
   output logic                     snp_hitm,
   output logic                     dat_valid,
   output logic [$clog2(BEATS)-1:0] dat_beat,
   output logic [DATA_W-1:0]        dat_data,
   output logic                     idle
);
   localparam int BEAT_W = $clog2(BEATS);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

   resp_state_e       state_q;
   logic [BEAT_W-1:0] beat_q;
   logic [DATA_W-1:0] line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RS_IDLE;
         beat_q  <= '0;
         line_q  <= '0;
      end else begin
         case (state_q)
            RS_IDLE: begin
               if (start_rd) state_q <= RS_SNOOP;
            end
            RS_SNOOP: begin
               if (res_valid) begin
                  line_q  <= res_data;
                  beat_q  <= '0;
                  state_q <= RS_DATA;
               end
            end
            RS_DATA: begin
               if (beat_q == LAST_BEAT) begin
                  state_q <= RS_IDLE;
                  beat_q  <= '0;
               end else begin
                  beat_q <= beat_q + BEAT_W'(1);
               end
            end
            default: state_q <= RS_IDLE;
         endcase
      end
   end

   always_comb begin
      snp_stall = (state_q == RS_SNOOP) && !res_valid;
      snp_hitm  = (state_q == RS_SNOOP) && res_valid;
      dat_valid = (state_q == RS_DATA);
      dat_beat  = beat_q;
      dat_data  = (dat_valid && beat_q == '0) ? line_q : '0;
      idle      = (state_q == RS_IDLE);
   end

endmodule

// File: rtl/busmbx_stats.sv
`timescale 1ns/1ps
module busmbx_stats #(
   parameter int STAT_W = 16,
   parameter int NUM    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM-1:0]        inc,
   output logic [NUM*STAT_W-1:0] counts
);
   generate
      for (genvar i = 0; i < NUM; i++) begin : g_cnt
         logic [STAT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (inc[i])
               cnt_q <= cnt_q + STAT_W'(1);
         end
         assign counts[i*STAT_W +: STAT_W] = cnt_q;
      end
   endgenerate

endmodule

// File: rtl/busmbx_offload.sv
`timescale 1ns/1ps
module busmbx_offload
   import busmbx_pkg::*;
#(
   parameter int ADDR_W     = 36,
   parameter int DATA_W     = 64,
   parameter int LINE_BYTES = 32,
   parameter int FUNC_LAT   = 4,
   parameter int STAT_W     = 16,
   parameter logic [ADDR_W-13:0] RESET_PFN = '0,
   localparam int PAGE_BITS = 12,
   localparam int BEATS     = (LINE_BYTES * 8) / DATA_W,
   localparam int BEAT_W    = $clog2(BEATS),
   localparam int PFN_W     = ADDR_W - PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_base_we,
   input  logic [PFN_W-1:0]  cfg_base_pfn,
   input  logic              bus_req_valid,
   input  logic              bus_req_write,
   input  logic [ADDR_W-1:0] bus_req_addr,
   input  logic [DATA_W-1:0] bus_req_wdata,
   output logic              snp_stall,
   output logic              snp_hitm,
   output logic              dat_valid,
   output logic [BEAT_W-1:0] dat_beat,
   output logic [DATA_W-1:0] dat_data,
   output logic [STAT_W-1:0] stat_writes,
   output logic [STAT_W-1:0] stat_reads,
   output logic [STAT_W-1:0] stat_stalls
);
   generate
      if (ADDR_W <= PAGE_BITS) begin : g_bad_addr
         $error("ADDR_W must exceed the page offset width");
      end
      if (DATA_W < 24) begin : g_bad_data
         $error("DATA_W too narrow for the result");
      end
      if ((LINE_BYTES * 8) % DATA_W != 0 || BEATS < 2) begin : g_bad_line
         $error("line must split into at least two whole beats");
      end
      if (FUNC_LAT < 1) begin : g_bad_lat
         $error("FUNC_LAT must be at least 1");
      end
   endgenerate

   logic              wr_call;
   logic              rd_call;
   call_args_t        args;
   logic [PFN_W-1:0]  base_pfn;
   logic              res_valid;
   logic [DATA_W-1:0] res_data;
   logic              resp_idle;
   logic [3*STAT_W-1:0] counts;

   busmbx_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .RESET_PFN(RESET_PFN)
   ) u_decode (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_base_we), .cfg_pfn(cfg_base_pfn),
      .req_valid(bus_req_valid), .req_write(bus_req_write),
      .req_addr(bus_req_addr), .req_wdata(bus_req_wdata),
      .resp_idle(resp_idle),
      .wr_call(wr_call), .rd_call(rd_call), .args(args), .page_pfn(base_pfn)
   );

   busmbx_func #(.DATA_W(DATA_W), .FUNC_LAT(FUNC_LAT)) u_func (
      .clk(clk), .rst_n(rst_n), .start(wr_call), .args(args),
      .res_valid(res_valid), .res_data(res_data)
   );

   busmbx_resp #(.DATA_W(DATA_W), .BEATS(BEATS)) u_resp (
      .clk(clk), .rst_n(rst_n), .start_rd(rd_call),
      .res_valid(res_valid), .res_data(res_data),
      .snp_stall(snp_stall), .snp_hitm(snp_hitm),
      .dat_valid(dat_valid), .dat_beat(dat_beat), .dat_data(dat_data),
      .idle(resp_idle)
   );

   busmbx_stats #(.STAT_W(STAT_W), .NUM(3)) u_stats (
      .clk(clk), .rst_n(rst_n),
      .inc({snp_stall, rd_call, wr_call}),
      .counts(counts)
   );

   assign stat_writes = counts[0*STAT_W +: STAT_W];
   assign stat_reads  = counts[1*STAT_W +: STAT_W];
   assign stat_stalls = counts[2*STAT_W +: STAT_W];

endmodule

// File: rtl/busmbx_offload_chk.sv
`timescale 1ns/1ps
module busmbx_offload_chk #(
   parameter int ADDR_W = 36,
   parameter int DATA_W = 64,
   parameter int STAT_W = 16,
   parameter int BEATS  = 4,
   parameter int PFN_W  = 24
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_req_valid,
   input logic                     bus_req_write,
   input logic [ADDR_W-1:0]        bus_req_addr,
   input logic                     snp_stall,
   input logic                     snp_hitm,
   input logic                     dat_valid,
   input logic [$clog2(BEATS)-1:0] dat_beat,
   input logic [DATA_W-1:0]        dat_data,
   input logic [STAT_W-1:0]        stat_writes,
   input logic [STAT_W-1:0]        stat_stalls,
   input logic [PFN_W-1:0]         base_pfn
);
   localparam int BEAT_W = $clog2(BEATS);

   logic quiet;
   logic on_page;
   assign quiet   = !snp_stall && !snp_hitm && !dat_valid;
   assign on_page = bus_req_addr[ADDR_W-1:ADDR_W-PFN_W] == base_pfn;

   p_stall_hitm_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(snp_stall && snp_hitm));

   p_claim_then_beat0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      snp_hitm |=> dat_valid && dat_beat == '0);

   p_beat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dat_valid && dat_beat != BEAT_W'(BEATS - 1)
      |=> dat_valid && dat_beat == $past(dat_beat) + BEAT_W'(1));

   p_tail_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dat_valid && dat_beat != '0 |-> dat_data == '0);

   p_offpage_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      quiet && bus_req_valid && !on_page |=> quiet);

   p_stall_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      snp_stall |=> stat_stalls == $past(stat_stalls) + STAT_W'(1));

   p_write_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && bus_req_write && on_page
      |=> stat_writes == $past(stat_writes) + STAT_W'(1));

endmodule

bind busmbx_offload busmbx_offload_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W), .BEATS(BEATS), .PFN_W(PFN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .bus_req_valid(bus_req_valid), .bus_req_write(bus_req_write),
   .bus_req_addr(bus_req_addr),
   .snp_stall(snp_stall), .snp_hitm(snp_hitm),
   .dat_valid(dat_valid), .dat_beat(dat_beat), .dat_data(dat_data),
   .stat_writes(stat_writes), .stat_stalls(stat_stalls),
   .base_pfn(base_pfn)
);

// File: tb/busmbx_offload_bench.sv
`timescale 1ns/1ps
module busmbx_offload_bench;
   localparam int ADDR_W   = 36;
   localparam int DATA_W   = 64;
   localparam int STAT_W   = 16;
   localparam int FUNC_LAT = 4;
   localparam int BEATS    = 4;
   localparam int PFN_W    = ADDR_W - 12;

   typedef struct packed {
      logic [1:0]  kind;
      logic [1:0]  level;
      logic [15:0] extra;
      logic [7:0]  junk;
      logic [31:0] expect_res;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VEC [NVEC] = '{
      '{2'd0, 2'd0, 16'd0,     8'h00, 32'd3},
      '{2'd1, 2'd1, 16'd5,     8'h00, 32'd18},
      '{2'd2, 2'd2, 16'd100,   8'h00, 32'd136},
      '{2'd3, 2'd3, 16'd0,     8'h00, 32'd124},
      '{2'd0, 2'd3, 16'd4096,  8'hFF, 32'd4216},
      '{2'd3, 2'd1, 16'd65535, 8'h2A, 32'd65550}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_base_we = 1'b0;
   logic [PFN_W-1:0]  cfg_base_pfn = '0;
   logic              bus_req_valid = 1'b0;
   logic              bus_req_write = 1'b0;
   logic [ADDR_W-1:0] bus_req_addr = '0;
   logic [DATA_W-1:0] bus_req_wdata = '0;
   logic              snp_stall, snp_hitm, dat_valid;
   logic [1:0]        dat_beat;
   logic [DATA_W-1:0] dat_data;
   logic [STAT_W-1:0] stat_writes, stat_reads, stat_stalls;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   busmbx_offload #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FUNC_LAT(FUNC_LAT), .STAT_W(STAT_W))
   u_busmbx_offload (
      .clk(clk), .rst_n(rst_n),
      .cfg_base_we(cfg_base_we), .cfg_base_pfn(cfg_base_pfn),
      .bus_req_valid(bus_req_valid), .bus_req_write(bus_req_write),
      .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
      .snp_stall(snp_stall), .snp_hitm(snp_hitm),
      .dat_valid(dat_valid), .dat_beat(dat_beat), .dat_data(dat_data),
      .stat_writes(stat_writes), .stat_reads(stat_reads), .stat_stalls(stat_stalls)
   );

   function automatic logic [ADDR_W-1:0] mk_addr(input logic [PFN_W-1:0] pfn,
      input logic [1:0] k, input logic [1:0] l, input logic [7:0] j);
      return {pfn, j[7:3], l, k, j[2:0]};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic bus_op(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      bus_req_valid = 1'b1;
      bus_req_write = wr;
      bus_req_addr  = a;
      bus_req_wdata = d;
      @(negedge clk);
      bus_req_valid = 1'b0;
      bus_req_write = 1'b0;
   endtask

   // Called in the cycle after the read request edge.
   task automatic collect(input logic [63:0] exp_res, input int exp_stall, input string tag);
      int n = 0;
      while (snp_stall && n < 1000) begin
         n++;
         @(negedge clk);
      end
      chk({tag, " stall cycles"}, 64'(n), 64'(exp_stall));
      chk({tag, " claim"}, 64'(snp_hitm), 64'd1);
      @(negedge clk);
      for (int b = 0; b < BEATS; b++) begin
         chk($sformatf("%s R7 beat %0d valid/index", tag, b),
             {dat_valid, 6'd0, dat_beat}, {1'b1, 6'd0, 2'(b)});
         chk($sformatf("%s R7 beat %0d data", tag, b), dat_data, (b == 0) ? exp_res : 64'd0);
         @(negedge clk);
      end
      chk({tag, " R7 data ends"}, 64'(dat_valid), 64'd0);
   endtask

   task automatic expect_quiet(input string tag);
      for (int c = 0; c < 3; c++) begin
         chk($sformatf("%s quiet cycle %0d", tag, c), {snp_stall, snp_hitm, dat_valid}, 3'b000);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [STAT_W-1:0] w0, r0, s0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 outputs", {snp_stall, snp_hitm, dat_valid}, 3'b000);
      chk("R1 counters", {stat_writes, stat_reads, stat_stalls}, 48'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 R5 vector table: read lands exactly on the ready edge
      for (int i = 0; i < NVEC; i++) begin
         bus_op(1'b1, mk_addr('0, VEC[i].kind, VEC[i].level, VEC[i].junk), 64'(VEC[i].extra));
         repeat (FUNC_LAT - 1) @(negedge clk);
         bus_op(1'b0, mk_addr('0, 2'd0, 2'd0, 8'h00), '0);
         collect(64'(VEC[i].expect_res), 0, $sformatf("R4 R5 vec %0d", i));
      end
      chk("R9 writes after table", 64'(stat_writes), 64'(NVEC));
      chk("R9 reads after table", 64'(stat_reads), 64'(NVEC));
      chk("R9 stalls after table", 64'(stat_stalls), 64'd0);

      // R6 early read stalls FUNC_LAT-1 cycles
      s0 = stat_stalls;
      bus_op(1'b1, mk_addr('0, 2'd1, 2'd1, 8'h00), 64'd5);
      bus_op(1'b0, mk_addr('0, 2'd0, 2'd0, 8'h00), '0);
      collect(64'd18, FUNC_LAT - 1, "R6 early read");
      chk("R9 stall counter", 64'(stat_stalls - s0), 64'(FUNC_LAT - 1));

      // R10 re-read returns same result
      bus_op(1'b0, mk_addr('0, 2'd0, 2'd0, 8'h00), '0);
      collect(64'd18, 0, "R10 re-read");

      // R8 read during an active response is ignored
      r0 = stat_reads;
      bus_op(1'b1, mk_addr('0, 2'd2, 2'd2, 8'h00), 64'd100);
      bus_op(1'b0, mk_addr('0, 2'd0, 2'd0, 8'h00), '0);
      bus_op(1'b0, mk_addr('0, 2'd0, 2'd0, 8'h00), '0);
      collect(64'd136, FUNC_LAT - 2, "R8 busy read");
      expect_quiet("R8 no second reply");
      chk("R8 read count", 64'(stat_reads - r0), 64'd1);

      // R2 off-page traffic ignored
      w0 = stat_writes; r0 = stat_reads;
      bus_op(1'b1, mk_addr(24'h000005, 2'd3, 2'd3, 8'h00), 64'd7);
      bus_op(1'b0, mk_addr(24'h000005, 2'd0, 2'd0, 8'h00), '0);
      expect_quiet("R2 off-page read");
      chk("R2 counters", {stat_writes - w0, stat_reads - r0}, 32'd0);
      bus_op(1'b0, mk_addr('0, 2'd0, 2'd0, 8'h00), '0);
      collect(64'd136, 0, "R2 result kept");

      // R3 move the page
      cfg_base_pfn = 24'h000ABC;
      cfg_base_we  = 1'b1;
      @(negedge clk);
      cfg_base_we  = 1'b0;
      bus_op(1'b0, mk_addr('0, 2'd0, 2'd0, 8'h00), '0);
      expect_quiet("R3 old page");
      bus_op(1'b1, mk_addr(24'h000ABC, 2'd0, 2'd0, 8'h00), 64'd0);
      repeat (FUNC_LAT - 1) @(negedge clk);
      bus_op(1'b0, mk_addr(24'h000ABC, 2'd0, 2'd0, 8'h00), '0);
      collect(64'd3, 0, "R3 new page");

      // R6 write during stall: newest result delivered
      bus_op(1'b1, mk_addr(24'h000ABC, 2'd0, 2'd3, 8'h00), 64'd4096);
      bus_op(1'b0, mk_addr(24'h000ABC, 2'd0, 2'd0, 8'h00), '0);
      bus_op(1'b1, mk_addr(24'h000ABC, 2'd3, 2'd1, 8'h00), 64'd65535);
      collect(64'd65550, FUNC_LAT, "R6 restart in stall");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule